// File: doc/BRIEF.md
# Twin Down-Counter Timer

This peripheral holds two 32-bit countdown timers that sit behind a single word-addressed register window. Software reaches them over a plain register bus carrying a select, a write strobe, a byte address, write data and combinational read data. Each timer has its own interrupt line. A write takes effect at the clock edge where `bus_sel` and `bus_write` are both high. A read returns the addressed word in the same cycle. The bus has no wait states and no error response.

Each timer counts down one step per clock while it runs. When it sits at zero and is still running, it raises its expiry flag. In periodic mode it then refills from its reload value. In one-shot mode it stays at zero and switches itself off. The reload value can be replaced in two ways: a direct load restarts the count, and a background load changes only what the next refill uses. Word indices above the two timers belong to an unimplemented 64-bit cascaded mode. They read as zero and ignore writes.

Top module: `twin_down_timer`

## Requirements
- R1: After reset every timer register reads 0 and both `irq` bits are low.
- R2: The word index is the byte address shifted right by two. Words 0 to 5 belong to timer 0 and words 6 to 11 belong to timer 1. Within a timer the word offsets are: 0 live count (read-only), 1 load, 2 background load, 3 control, 4 raw status, 5 masked status (read-only).
- R3: A write to the load word sets both the reload value and the live count at that edge. Reads of word offset 1 and word offset 2 both return the reload value.
- R4: A write to the background load word changes only the reload value. The live count keeps stepping undisturbed.
- R5: Control bit 0 runs the timer, bit 1 selects one-shot (1) or periodic (0), and bit 2 enables the interrupt. A control write with bit 0 set restarts the count from the reload value. A control write with bit 0 clear freezes the count where it is.
- R6: While running, a nonzero count drops by one per clock. A count of zero that is still running sets raw status bit 0 at the next edge, so an interval spans reload+1 clocks.
- R7: In periodic mode, expiry refills the count from the reload value and the timer keeps running.
- R8: In one-shot mode, expiry leaves the count at zero and clears control bit 0.
- R9: Writing 1 to raw status bit 0 clears the flag and writing 0 leaves it alone. If an expiry happens in the same cycle as the clear, the flag stays set.
- R10: Masked status bit 0, and the timer's `irq` bit, equal raw bit 0 AND control bit 2.
- R11: Word indices 12 and above read as 0 and writes to them change nothing. Writes to the live-count and masked-status words are dropped.
- R12: The two timers are fully independent. Bus writes to one timer never alter the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 2 | Interrupt per timer, bit i for timer i |

## Verification
A corrupted count or reload value appears on a live-count read in the very next cycle. It also shows later as an expiry that arrives at the wrong clock, which the bench catches by sampling at the exact cycle the flag should rise. A wrong mode or enable bit shows as a timer that refills when it should stop, or that keeps counting after a freeze. The raw flag and interrupt are compared at the port in the cycle after each set or clear. A decode fault aliases one timer onto the other or onto the high words, and a cross-read shows it at once.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int REGS_PER_CH = 6;
  localparam int CTL_RUN  = 0;
  localparam int CTL_ONCE = 1;
  localparam int CTL_IE   = 2;
  localparam int CTL_W    = 3;

  typedef enum logic [2:0] {
    W_VALUE  = 3'd0,
    W_LOAD   = 3'd1,
    W_BGLOAD = 3'd2,
    W_CTRL   = 3'd3,
    W_RAW    = 3'd4,
    W_MASKED = 3'd5
  } word_e;
endpackage

// File: rtl/dtmr_decode.sv
module dtmr_decode
  import dtmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [CH_W-1:0]   ch_sel,
  output word_e             slot
);
  logic [ADDR_W-1:0] idx;
  int                off_v;

  assign idx = addr >> 2;

  always_comb begin
    hit    = 1'b0;
    ch_sel = '0;
    slot   = W_VALUE;
    off_v  = 0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(idx) >= i * REGS_PER_CH && int'(idx) < (i + 1) * REGS_PER_CH) begin
        hit    = 1'b1;
        ch_sel = CH_W'(i);
        off_v  = int'(idx) - i * REGS_PER_CH;
        slot   = word_e'(off_v[2:0]);
      end
    end
  end
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
  import dtmr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  word_e            slot,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_data,
  output logic             irq,
  output logic [DW-1:0]    count_o,
  output logic [DW-1:0]    reload_o,
  output logic [CTL_W-1:0] ctrl_o,
  output logic             flag_o
);
  logic [DW-1:0]    count_q, count_n;
  logic [DW-1:0]    reload_q, reload_n;
  logic [CTL_W-1:0] ctrl_q, ctrl_n;
  logic             flag_q, flag_n;

  always_comb begin
    count_n  = count_q;
    reload_n = reload_q;
    ctrl_n   = ctrl_q;
    flag_n   = flag_q;
    // a clear request is applied first so that a same-cycle expiry wins
    if (wr_en && slot == W_RAW && wdata[0])
      flag_n = 1'b0;
    if (ctrl_q[CTL_RUN]) begin
      if (count_q == '0) begin
        flag_n = 1'b1;
        if (ctrl_q[CTL_ONCE]) ctrl_n[CTL_RUN] = 1'b0;
        else                  count_n = reload_q;
      end else begin
        count_n = count_q - DW'(1);
      end
    end
    if (wr_en) begin
      unique case (slot)
        W_LOAD: begin
          reload_n = wdata;
          count_n  = wdata;
        end
        W_BGLOAD: reload_n = wdata;
        W_CTRL: begin
          ctrl_n  = wdata[CTL_W-1:0];
          count_n = wdata[CTL_RUN] ? reload_q : count_q;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
    end else begin
      count_q  <= count_n;
      reload_q <= reload_n;
      ctrl_q   <= ctrl_n;
      flag_q   <= flag_n;
    end
  end

  always_comb begin
    unique case (slot)
      W_VALUE:          rd_data = count_q;
      W_LOAD, W_BGLOAD: rd_data = reload_q;
      W_CTRL:           rd_data = DW'(ctrl_q);
      W_RAW:            rd_data = DW'(flag_q);
      W_MASKED:         rd_data = DW'(flag_q & ctrl_q[CTL_IE]);
      default:          rd_data = '0;
    endcase
  end

  assign irq      = flag_q & ctrl_q[CTL_IE];
  assign count_o  = count_q;
  assign reload_o = reload_q;
  assign ctrl_o   = ctrl_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/twin_down_timer.sv
module twin_down_timer
  import dtmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 32,
  parameter int NUM_CH = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  logic                           hit;
  logic [CH_W-1:0]                ch_sel;
  word_e                          slot;
  logic [NUM_CH-1:0][DW-1:0]      ch_rd;
  logic [NUM_CH-1:0][DW-1:0]      ch_count;
  logic [NUM_CH-1:0][DW-1:0]      ch_reload;
  logic [NUM_CH-1:0][CTL_W-1:0]   ch_ctrl;
  logic [NUM_CH-1:0]              ch_flag;

  dtmr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .addr(bus_addr), .hit(hit), .ch_sel(ch_sel), .slot(slot)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic wr_en;
    assign wr_en = bus_sel && bus_write && hit && (ch_sel == CH_W'(g));
    dtmr_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .slot(slot),
      .wdata(bus_wdata), .rd_data(ch_rd[g]), .irq(irq[g]),
      .count_o(ch_count[g]), .reload_o(ch_reload[g]),
      .ctrl_o(ch_ctrl[g]), .flag_o(ch_flag[g])
    );
  end

  assign bus_rdata = hit ? ch_rd[ch_sel] : '0;
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker
  import dtmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 32,
  parameter int NUM_CH = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_sel,
  input logic                         bus_write,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic [DW-1:0]                bus_rdata,
  input logic [NUM_CH-1:0]            irq,
  input logic [NUM_CH-1:0][DW-1:0]    ch_count,
  input logic [NUM_CH-1:0][DW-1:0]    ch_reload,
  input logic [NUM_CH-1:0][CTL_W-1:0] ch_ctrl,
  input logic [NUM_CH-1:0]            ch_flag
);
  logic [ADDR_W-1:0] word;
  logic [NUM_CH-1:0] wr_to;
  logic              rd_high;

  assign word    = bus_addr >> 2;
  assign rd_high = bus_sel && !bus_write && int'(word) >= NUM_CH * REGS_PER_CH;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++)
      wr_to[i] = bus_sel && bus_write && int'(word) >= i * REGS_PER_CH &&
                 int'(word) < (i + 1) * REGS_PER_CH;
  end

  AST_HIGH_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_high |-> bus_rdata == '0); // R11

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_MASK_READ_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_write && int'(word) == g * REGS_PER_CH + 5)
        |-> bus_rdata == DW'(irq[g])); // R10

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_ctrl[g][CTL_RUN] && ch_count[g] != '0 && !wr_to[g])
        |=> ch_count[g] == $past(ch_count[g]) - DW'(1)); // R6

    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_ctrl[g][CTL_RUN] && !ch_ctrl[g][CTL_ONCE] && ch_count[g] == '0 && !wr_to[g])
        |=> ch_flag[g] && ch_count[g] == $past(ch_reload[g])); // R7

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_ctrl[g][CTL_RUN] && ch_ctrl[g][CTL_ONCE] && ch_count[g] == '0 && !wr_to[g])
        |=> ch_flag[g] && !ch_ctrl[g][CTL_RUN] && ch_count[g] == '0); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_ctrl[g][CTL_RUN] && !wr_to[g]) |=> $stable(ch_count[g])); // R5
  end
endmodule

bind twin_down_timer dtmr_checker #(.ADDR_W(ADDR_W), .DW(DW), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq),
  .ch_count(ch_count), .ch_reload(ch_reload), .ch_ctrl(ch_ctrl), .ch_flag(ch_flag)
);

// File: tb/twin_down_timer_test.sv
`timescale 1ns/1ps
module twin_down_timer_test;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_IDLE = 2'd2, OP_IRQ = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 53;
  localparam vec_t VEC [NV] = '{
    '{OP_RD,   8'h0C, 32'd0,      32'd0,  8'd1},  // R1 ctrl0 clear
    '{OP_RD,   8'h00, 32'd0,      32'd0,  8'd1},  // R1 count0 clear
    '{OP_IRQ,  8'h00, 32'd0,      32'd0,  8'd1},  // R1 irq low
    '{OP_WR,   8'h04, 32'd10,     32'd0,  8'd3},  // R3 load0 = 10
    '{OP_RD,   8'h00, 32'd0,      32'd10, 8'd3},  // R3 count loaded at once
    '{OP_RD,   8'h08, 32'd0,      32'd10, 8'd3},  // R3 word 2 shows reload
    '{OP_WR,   8'h0C, 32'd1,      32'd0,  8'd5},  // R5 run, periodic
    '{OP_RD,   8'h00, 32'd0,      32'd10, 8'd5},  // R5 restarted from reload
    '{OP_RD,   8'h00, 32'd0,      32'd9,  8'd6},  // R6 one step
    '{OP_IDLE, 8'h00, 32'd8,      32'd0,  8'd6},
    '{OP_RD,   8'h00, 32'd0,      32'd0,  8'd6},  // R6 reached zero
    '{OP_RD,   8'h10, 32'd0,      32'd1,  8'd6},  // R6 flag after zero
    '{OP_RD,   8'h00, 32'd0,      32'd9,  8'd7},  // R7 refilled and stepping
    '{OP_RD,   8'h14, 32'd0,      32'd0,  8'd10}, // R10 masked off
    '{OP_IRQ,  8'h00, 32'd0,      32'd0,  8'd10}, // R10 irq masked
    '{OP_WR,   8'h0C, 32'd5,      32'd0,  8'd5},  // R5 run + ie
    '{OP_IRQ,  8'h00, 32'd0,      32'd1,  8'd10}, // R10 irq0 up
    '{OP_RD,   8'h14, 32'd0,      32'd1,  8'd10}, // R10 masked on
    '{OP_WR,   8'h10, 32'd0,      32'd0,  8'd9},  // R9 write 0
    '{OP_RD,   8'h10, 32'd0,      32'd1,  8'd9},  // R9 flag kept
    '{OP_WR,   8'h10, 32'd1,      32'd0,  8'd9},  // R9 write 1
    '{OP_IRQ,  8'h00, 32'd0,      32'd0,  8'd9},  // R9 irq dropped
    '{OP_RD,   8'h10, 32'd0,      32'd0,  8'd9},  // R9 flag cleared
    '{OP_WR,   8'h0C, 32'd0,      32'd0,  8'd5},  // R5 stop at 3
    '{OP_RD,   8'h00, 32'd0,      32'd3,  8'd5},  // R5 frozen
    '{OP_IDLE, 8'h00, 32'd3,      32'd0,  8'd5},
    '{OP_RD,   8'h00, 32'd0,      32'd3,  8'd5},  // R5 still frozen
    '{OP_WR,   8'h1C, 32'd4,      32'd0,  8'd12}, // R12 load1 = 4
    '{OP_WR,   8'h24, 32'd7,      32'd0,  8'd8},  // R8 one-shot + ie
    '{OP_RD,   8'h18, 32'd0,      32'd4,  8'd2},  // R2 timer 1 count word
    '{OP_WR,   8'h20, 32'd20,     32'd0,  8'd4},  // R4 background 20
    '{OP_RD,   8'h18, 32'd0,      32'd2,  8'd4},  // R4 count undisturbed
    '{OP_IDLE, 8'h00, 32'd4,      32'd0,  8'd8},
    '{OP_IRQ,  8'h00, 32'd0,      32'd2,  8'd8},  // R8 irq1 only
    '{OP_RD,   8'h18, 32'd0,      32'd0,  8'd8},  // R8 holds zero
    '{OP_RD,   8'h24, 32'd0,      32'd6,  8'd8},  // R8 run bit cleared
    '{OP_RD,   8'h1C, 32'd0,      32'd20, 8'd4},  // R4 reload now 20
    '{OP_RD,   8'h00, 32'd0,      32'd3,  8'd12}, // R12 timer 0 untouched
    '{OP_WR,   8'h30, 32'hFFFF,   32'd0,  8'd11}, // R11 high word write
    '{OP_RD,   8'h30, 32'd0,      32'd0,  8'd11}, // R11 high word reads 0
    '{OP_RD,   8'h24, 32'd0,      32'd6,  8'd11}, // R11 no alias
    '{OP_WR,   8'h00, 32'd99,     32'd0,  8'd11}, // R11 count word read-only
    '{OP_RD,   8'h00, 32'd0,      32'd3,  8'd11}, // R11 count kept
    '{OP_WR,   8'h14, 32'd1,      32'd0,  8'd11}, // R11 masked write
    '{OP_IRQ,  8'h00, 32'd0,      32'd2,  8'd11}, // R11 irq1 kept
    '{OP_WR,   8'h28, 32'd1,      32'd0,  8'd9},  // R9 clear timer 1
    '{OP_IRQ,  8'h00, 32'd0,      32'd0,  8'd9},  // R9 both low
    '{OP_RD,   8'h28, 32'd0,      32'd0,  8'd9},  // R9 flag1 cleared
    '{OP_WR,   8'h1C, 32'd0,      32'd0,  8'd9},  // R9 load1 = 0
    '{OP_WR,   8'h24, 32'd5,      32'd0,  8'd9},  // R9 periodic + ie
    '{OP_WR,   8'h28, 32'd1,      32'd0,  8'd9},  // R9 clear meets expiry
    '{OP_RD,   8'h28, 32'd0,      32'd1,  8'd9},  // R9 set wins
    '{OP_IRQ,  8'h00, 32'd0,      32'd2,  8'd9}   // R9 irq1 stays
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  twin_down_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    bus_sel   = 1'b0;
    bus_write = 1'b0;
    case (v.op)
      OP_WR: begin
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = v.addr; bus_wdata = v.data;
      end
      OP_RD: begin
        bus_sel = 1'b1; bus_addr = v.addr;
        #1 check(bus_rdata, v.exp, int'(v.req));
      end
      OP_IRQ: begin
        #1 check(32'(irq), v.exp, int'(v.req));
      end
      default: repeat (int'(v.data) - 1) @(negedge clk);
    endcase
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);
    // R1 reset mid-run clears everything
    @(negedge clk);
    bus_sel = 1'b0; bus_write = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    #1 check(32'(irq), 32'd0, 1);  // R1
    run_vec('{OP_RD, 8'h1C, 32'd0, 32'd0, 8'd1});  // R1 load1 cleared
    run_vec('{OP_RD, 8'h24, 32'd0, 32'd0, 8'd1});  // R1 ctrl1 cleared
    @(negedge clk) rst_n = 1'b1;
    run_vec('{OP_IDLE, 8'h00, 32'd3, 32'd0, 8'd1});
    run_vec('{OP_RD, 8'h28, 32'd0, 32'd0, 8'd1});  // R1 flag stays clear
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule